// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus target that holds a small bank of 8-bit configuration registers and presents their contents to the rest of the chip. It oversamples the bus clock and data lines with the system clock, finds start and stop conditions as data edges while the bus clock is high, and acknowledges bytes by pulling the data line low. The data line is modelled as an open-drain output: `sdaOe` high means the block pulls the line low.

A host updates the bank with a block write. The target address is followed by two header bytes, a command code and a byte count, which are acknowledged but otherwise ignored. Data bytes then fill the registers in order from index 0 upward. A host reads the bank with a block read. The block first returns a byte count and then the registers in order from index 0. Every register is 8 bits and all bytes travel MSB first. On reset the bank takes its power-on defaults: register 0 clears and the enable registers are all ones.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 reads 0x00 and registers 1 to 5 read 0xFF. `cfgRegs` carries register i in bits [8i+7:8i].
- R2: The address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged. Any other address byte is not acknowledged, and the bytes that follow it in the same transfer are neither acknowledged nor applied.
- R3: In a write, the two bytes after the address are acknowledged and discarded. Each following byte is acknowledged and stored in the next register, starting at register 0.
- R4: A stop condition ends a write after any whole byte. Only the registers whose byte was received completely change.
- R5: Write data bytes after the sixth are acknowledged and leave every register unchanged.
- R6: In a read, the block sends the byte count 6 and then registers 0 to 5, all MSB first. Any further byte that the host acknowledges for reads as 0xFF, so the line stays released.
- R7: When the host answers a read byte with a not-acknowledge, the block stops driving the data line for the rest of the transfer.
- R8: A start condition in the middle of a transfer abandons that transfer and begins a new address byte. Registers from bytes that were already complete keep their new values.
- R9: Bits clocked without a preceding start condition are ignored: nothing is acknowledged and nothing is stored. The block changes its data-line drive only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low reset; loads the register defaults |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | High pulls the data line low (acknowledge or a read 0 bit) |
| cfgRegs | output | NUM_REGS*8 | Register bank; register i sits in bits [8i+7:8i] |

## Verification
The assertions assume that each bus clock phase lasts several system clocks longer than the synchronizer delay. They also assume that the host moves the data line while the clock is high only to make a start or stop, and never while the block holds the line low. The stimulus keeps every phase at eight system clocks and moves host data only in the middle of the low phase. It releases its own drive one phase after each acknowledge slot and ends a read with a not-acknowledge, or after a byte that reads as all ones, before it issues a stop.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  // width of the byte index shared by control and datapath
  parameter int unsigned IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WACK, ST_WRX, ST_TX, ST_RACK, ST_IGNORE
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             rxShift;  // sample data line into receive shifter
    logic             regWr;    // commit receive shifter to regIdx
    logic             txLoad;   // load transmit shifter
    logic             txCount;  // with txLoad: load the byte count
    logic             txShift;  // advance transmit shifter one bit
    logic [IDX_W-1:0] regIdx;   // register addressed by regWr / txLoad
  } strobe_t;
endpackage

// File: rtl/cfgi2c_ctrl.sv
module cfgi2c_ctrl
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h69,
  parameter int unsigned HDR_BYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output strobe_t    strobe,
  output logic       sdaOe,
  output logic       sclSync,
  output logic       sdaSync
);
  localparam logic [IDX_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] HDR     = IDX_W'(HDR_BYTES);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclQ, sdaQ;
  logic       sclRise, sclFall, startDet, stopDet;
  state_e     state;
  logic [3:0] bitCnt;
  logic [IDX_W-1:0] byteCnt;
  logic       isRead, ackDrive, hostAck;

  // two-flop synchronizers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclQ    <= sclPipe[1];
      sdaQ    <= sdaPipe[1];
    end
  end

  assign sclSync  = sclPipe[1];
  assign sdaSync  = sdaPipe[1];
  assign sclRise  = sclSync & ~sclQ;
  assign sclFall  = ~sclSync & sclQ;
  assign startDet = sclSync & sclQ & sdaQ & ~sdaSync;
  assign stopDet  = sclSync & sclQ & ~sdaQ & sdaSync;

  always_comb begin
    strobe         = '0;
    strobe.rxShift = sclRise && (state == ST_ADDR || state == ST_WRX);
    strobe.regWr   = sclFall && state == ST_WRX && bitCnt == 4'd8 && byteCnt >= HDR;
    strobe.txLoad  = sclFall && ((state == ST_WACK && isRead) || (state == ST_RACK && hostAck));
    strobe.txCount = (state == ST_WACK);
    strobe.txShift = sclFall && state == ST_TX && bitCnt != 4'd7;
    strobe.regIdx  = (state == ST_WRX) ? byteCnt - HDR : byteCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteCnt  <= '0;
      isRead   <= 1'b0;
      ackDrive <= 1'b0;
      hostAck  <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WRX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_WRX) begin
              ackDrive <= 1'b1;
              state    <= ST_WACK;
              if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
            end else if (rxByte[7:1] == DEV_ADDR) begin
              ackDrive <= 1'b1;
              isRead   <= rxByte[0];
              byteCnt  <= '0;
              state    <= ST_WACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_WACK: if (sclFall) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          state    <= isRead ? ST_TX : ST_WRX;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == 4'd7) state <= ST_RACK;
          else bitCnt <= bitCnt + 4'd1;
        end
        ST_RACK: begin
          if (sclRise) begin
            hostAck <= ~sdaSync;
          end else if (sclFall) begin
            if (hostAck) begin
              state  <= ST_TX;
              bitCnt <= '0;
              if (byteCnt != CNT_MAX) byteCnt <= byteCnt + 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = ackDrive | (state == ST_TX && !txMsb);
endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs
  import cfgi2c_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 6,
  parameter logic [7:0]  REG0_DEFAULT = 8'h00,
  parameter logic [7:0]  REGN_DEFAULT = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic                  sdaBit,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regsFlat
);
  localparam logic [7:0] BYTE_COUNT = 8'(NUM_REGS);

  logic [7:0] regFile [NUM_REGS];
  logic [7:0] rxSr, txSr, readVal;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = (g == 0) ? REG0_DEFAULT : REGN_DEFAULT;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= RST_VAL;
      else if (strobe.regWr && strobe.regIdx == IDX_W'(g)) regFile[g] <= rxSr;
    end
    assign regsFlat[g*8 +: 8] = regFile[g];
  end

  // out-of-range index reads as all ones so the line stays released
  always_comb begin
    readVal = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (strobe.regIdx == IDX_W'(i)) readVal = regFile[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSr <= '0;
      txSr <= 8'hFF;
    end else begin
      if (strobe.rxShift) rxSr <= {rxSr[6:0], sdaBit};
      if (strobe.txLoad) txSr <= strobe.txCount ? BYTE_COUNT : readVal;
      else if (strobe.txShift) txSr <= {txSr[6:0], 1'b1};
    end
  end

  assign rxByte = rxSr;
  assign txMsb  = txSr[7];
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfgi2c_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 6,
  parameter logic [6:0]  DEV_ADDR     = 7'h69,
  parameter int unsigned HDR_BYTES    = 2,
  parameter logic [7:0]  REG0_DEFAULT = 8'h00,
  parameter logic [7:0]  REGN_DEFAULT = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  strobe_t    strobe;
  logic       sclSync, sdaSync, txMsb;
  logic [7:0] rxByte;

  cfgi2c_ctrl #(.DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .strobe(strobe), .sdaOe(sdaOe),
    .sclSync(sclSync), .sdaSync(sdaSync)
  );

  cfgi2c_regs #(.NUM_REGS(NUM_REGS), .REG0_DEFAULT(REG0_DEFAULT),
                .REGN_DEFAULT(REGN_DEFAULT)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaSync),
    .rxByte(rxByte), .txMsb(txMsb), .regsFlat(cfgRegs)
  );
endmodule

// File: rtl/cfgi2c_chk.sv
module cfgi2c_chk
  import cfgi2c_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclSync,
  input logic                  sdaOe,
  input strobe_t               strobe,
  input logic [NUM_REGS*8-1:0] cfgRegs
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclSync); // R9
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regWr |=> sdaOe); // R3
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rxShift, strobe.regWr, strobe.txLoad, strobe.txShift})); // R3
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.regWr |=> $stable(cfgRegs)); // R4
endmodule

bind cfg_i2c_slave cfgi2c_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaOe(sdaOe),
  .strobe(strobe), .cfgRegs(cfgRegs)
);

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
  localparam int NREG = 6;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1;
  logic sdaHost = 1'b1;
  logic sdaOe;
  logic [NREG*8-1:0] cfgRegs;
  wire  sdaBus = sdaHost & ~sdaOe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  always #2 clk = ~clk;

  cfg_i2c_slave i_cfg_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .cfgRegs(cfgRegs)
  );

  function automatic logic [7:0] defVal(int i);
    return (i == 0) ? 8'h00 : 8'hFF;
  endfunction

  function automatic logic [NREG*8-1:0] expFlat();
    logic [NREG*8-1:0] r;
    for (int i = 0; i < NREG; i++) r[i*8 +: 8] = model[i];
    return r;
  endfunction

  function automatic logic [7:0] expRead(int idx);
    return (idx < NREG) ? model[idx] : 8'hFF;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    if (!sclHost) begin
      sdaHost = 1'b1; q(); sclHost = 1'b1; q(); q();
    end
    sdaHost = 1'b0; q(); q(); sclHost = 1'b0; q();
  endtask

  task automatic busStop();
    sdaHost = 1'b0; q(); sclHost = 1'b1; q(); q(); sdaHost = 1'b1; q(); q();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      q(); sdaHost = b[i]; q(); sclHost = 1'b1; q(); q(); sclHost = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    q(); sdaHost = 1'b1; q(); sclHost = 1'b1; q();
    acked = !sdaBus;
    q(); sclHost = 1'b0;
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] b);
    sdaHost = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); q(); sclHost = 1'b1; q(); b[i] = sdaBus; q(); sclHost = 1'b0;
    end
    q(); sdaHost = !ackIt; q(); sclHost = 1'b1; q(); q(); sclHost = 1'b0;
    q(); sdaHost = 1'b1;
  endtask

  task automatic writeTxn(input int nData, input logic [63:0] data, input string req);
    bit ack;
    busStart();
    sendByte(8'hD2, ack); check("R2", "write address ack", ack, 1);
    sendByte(8'($urandom), ack); check("R3", "command ack", ack, 1);
    sendByte(8'($urandom), ack); check("R3", "count ack", ack, 1);
    for (int k = 0; k < nData; k++) begin
      sendByte(data[k*8 +: 8], ack); check(req, "data ack", ack, 1);
      if (k < NREG) model[k] = data[k*8 +: 8];
    end
    busStop();
    check(req, "register bank after write", cfgRegs, expFlat());
  endtask

  task automatic readTxn(input int nData, input string req);
    bit ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, ack); check("R2", "read address ack", ack, 1);
    readByte(1'b1, b); check("R6", "byte count", b, 8'd6);
    for (int k = 0; k < nData; k++) begin
      readByte(k != nData - 1, b); check(req, "read data", b, expRead(k));
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic [63:0] data;
    int n;
    n = int'($urandom(32'd4417));
    for (int i = 0; i < NREG; i++) model[i] = defVal(i);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset defaults at the port and through a read
    check("R1", "reset bank", cfgRegs, expFlat());
    check("R1", "no drive after reset", sdaOe, 0);
    readTxn(NREG, "R1");

    // R3 full write then read back
    data = {$urandom, $urandom};
    writeTxn(NREG, data, "R3");
    readTxn(NREG, "R6");

    // R4 partial write, stop after three data bytes
    data = {$urandom, $urandom};
    writeTxn(3, data, "R4");
    readTxn(NREG, "R4");

    // R5 extra bytes acknowledged and dropped
    data = {$urandom, $urandom};
    writeTxn(8, data, "R5");
    readTxn(NREG, "R5");

    // R2 foreign addresses
    busStart();
    sendByte(8'hA4, ack); check("R2", "foreign address nack", ack, 0);
    sendByte(8'h11, ack); check("R2", "byte after foreign address", ack, 0);
    sendByte(8'h22, ack); check("R2", "byte after foreign address", ack, 0);
    busStop();
    busStart();
    sendByte(8'hD0, ack); check("R2", "near address nack", ack, 0);
    busStop();
    check("R2", "bank after foreign traffic", cfgRegs, expFlat());

    // R7 host nack after the count byte releases the line
    busStart();
    sendByte(8'hD3, ack); check("R2", "read address ack", ack, 1);
    readByte(1'b0, b); check("R7", "count before nack", b, 8'd6);
    q(); q();
    check("R7", "line released after nack", sdaOe, 0);
    sendBits(8'h00, 8);
    check("R7", "no drive while clocking after nack", sdaOe, 0);
    busStop();

    // R6 byte past the last register reads all ones
    readTxn(NREG + 1, "R6");

    // R8 repeated start in the middle of a write
    busStart();
    sendByte(8'hD2, ack); check("R8", "address ack", ack, 1);
    sendByte(8'h00, ack);
    sendByte(8'h06, ack);
    sendByte(8'h5A, ack); check("R8", "first data ack", ack, 1);
    model[0] = 8'h5A;
    sendBits(8'hC3, 4);
    busStart();
    sendByte(8'hD3, ack); check("R8", "address after repeated start", ack, 1);
    readByte(1'b1, b); check("R8", "count after repeated start", b, 8'd6);
    readByte(1'b1, b); check("R8", "register 0 kept", b, model[0]);
    readByte(1'b0, b); check("R8", "register 1 untouched", b, model[1]);
    busStop();
    check("R8", "bank after repeated start", cfgRegs, expFlat());

    // R9 clocking without a start condition
    sclHost = 1'b0; q();
    sendByte(8'hD2, ack); check("R9", "no ack without start", ack, 0);
    sendByte(8'h77, ack); check("R9", "no ack without start", ack, 0);
    busStop();
    check("R9", "bank unchanged without start", cfgRegs, expFlat());

    // random partial writes with read back
    for (int it = 0; it < 8; it++) begin
      n = int'($urandom_range(0, 8));
      data = {$urandom, $urandom};
      writeTxn(n, data, (n > NREG) ? "R5" : "R4");
      readTxn(NREG, "R3");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule